// File: doc/BRIEF.md
# Sub-Word Register Access Adapter

This adapter sits between a narrow-capable request bus and a register block that only understands whole 32-bit words. A requester may issue 8-bit, 16-bit or 32-bit reads and writes; the adapter turns each one into accesses the register block can handle, always at the word-aligned address. Narrow reads fetch the whole word and slide it down so that the addressed byte appears at bit 0.

Narrow writes are handled by register class, which is chosen per word address through parameter masks. Ordinary storage registers get a read-modify-write: the old word is fetched, a 16-bit window starting at the addressed byte lane is cleared, and the new data, shifted into that lane, is ORed in. Registers that act only on 1-bits (clear-on-one status words, set and clear aliases) receive the shifted data with zeros in every other bit and are never read. Narrow writes to read-only words are dropped, unknown words are refused with an error flag, and full-word accesses go through untouched.

The upstream side uses a valid/ready handshake where the response (read data and error flag) is valid in the cycle the request is accepted; the requester holds its request stable until ready. The downstream side is a single-cycle port whose read data is returned combinationally in the cycle of the read.

Top module: `sub_word_adapter`

## Requirements
- R1: Out of reset, with no request pending, the adapter drives no downstream access (dnValid = 0) and holds reqReady low.
- R2: Every downstream access uses reqAddr with bits [1:0] forced to zero, and a read of size code 0 (byte) or 1 (half) completes in one cycle with rspRdata equal to the fetched word shifted right by 8 times reqAddr[1:0], upper bits zero-filled.
- R3: Size code 2 (word) reads and writes to any known word, including read-only ones, complete in one cycle; write data reaches dnWdata unchanged and read data reaches rspRdata unchanged.
- R4: A narrow write to a storage word issues a downstream read in the first cycle with reqReady low, then a downstream write in the second cycle with reqReady high; the written word is the old word with bits [8L+15:8L] (L = reqAddr[1:0], clipped at bit 31) cleared, ORed with the new data shifted left by 8L.
- R5: For a byte write the data is zero-extended to 16 bits before merging, so the byte above the addressed lane is also cleared; at lane 3 only bits [31:24] change.
- R6: A narrow write to a word whose ACTION_MASK bit is set completes in one cycle as a single downstream write of the data shifted left by 8 times reqAddr[1:0] with all other bits zero, and no downstream read.
- R7: A narrow write to a word whose RO_MASK bit is set completes in one cycle with rspErr low and no downstream access, leaving the word unchanged.
- R8: A request to a word whose KNOWN_MASK bit is clear, or with size code 3, completes in one cycle with rspErr high and no downstream access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream request present |
| reqReady | output | 1 | Request accepted this cycle; response fields valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 half, 2 word, 3 invalid |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Write data, right-aligned for narrow sizes |
| rspRdata | output | 32 | Read data, shifted for narrow sizes |
| rspErr | output | 1 | Request refused |
| dnValid | output | 1 | Downstream access this cycle |
| dnWrite | output | 1 | Downstream access is a write |
| dnAddr | output | ADDR_W | Word-aligned downstream address |
| dnWdata | output | 32 | Downstream write word |
| dnRdata | input | 32 | Downstream read word, same cycle |

## Verification
The hardest case to reach is the merge window at its edges: a byte write silently wiping its upper neighbour, and a lane-3 access whose window runs off the top of the word. The bench first loads known full-word patterns with distinct bytes, then issues byte and half writes at lanes 1 and 3, and reads the word back whole so every lost or kept byte is visible. It also counts downstream reads around each action-register write to show none occurred, and pairs each read-only or refused access with a later full read proving the word untouched.

// File: rtl/sub_word_pkg.sv
package sub_word_pkg;

  localparam int DATA_W         = 32;
  localparam int LANE_W         = 8;
  localparam int MERGE_WINDOW_W = 16;
  localparam int SHIFT_W        = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } access_size_e;

  typedef enum logic {
    ST_IDLE     = 1'b0,
    ST_MERGE_WR = 1'b1
  } ctrl_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureMerge;  // latch merged word from the read phase
    logic useMerged;     // drive the latched merged word downstream
  } dp_strobe_t;

endpackage

// File: rtl/sub_word_ctrl.sv
module sub_word_ctrl
  import sub_word_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [2**(ADDR_W-2)-1:0] KNOWN_MASK  = 64'h0000_0000_0000_FFFF,
  parameter logic [2**(ADDR_W-2)-1:0] RO_MASK     = 64'h0000_0000_0000_0002,
  parameter logic [2**(ADDR_W-2)-1:0] ACTION_MASK = 64'h0000_0000_0000_0070
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        sizeCode,
  input  logic [ADDR_W-3:0] wordIdx,
  output logic              reqReady,
  output logic              rspErr,
  output logic              dnValid,
  output logic              dnWrite,
  output dp_strobe_t        strobe
);

  ctrl_state_e state, nextState;

  logic isKnown, isNarrow, isReadOnly, isAction;

  assign isKnown    = KNOWN_MASK[wordIdx] && (sizeCode != SZ_BAD);
  assign isNarrow   = (sizeCode == SZ_BYTE) || (sizeCode == SZ_HALF);
  assign isReadOnly = RO_MASK[wordIdx];
  assign isAction   = ACTION_MASK[wordIdx];

  always_comb begin
    nextState = state;
    reqReady  = 1'b0;
    rspErr    = 1'b0;
    dnValid   = 1'b0;
    dnWrite   = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!isKnown) begin
            reqReady = 1'b1;
            rspErr   = 1'b1;
          end else if (!reqWrite) begin
            dnValid  = 1'b1;
            reqReady = 1'b1;
          end else if (!isNarrow) begin
            dnValid  = 1'b1;
            dnWrite  = 1'b1;
            reqReady = 1'b1;
          end else if (isReadOnly) begin
            reqReady = 1'b1;
          end else if (isAction) begin
            dnValid  = 1'b1;
            dnWrite  = 1'b1;
            reqReady = 1'b1;
          end else begin
            // storage register: fetch now, write merged word next cycle
            dnValid             = 1'b1;
            strobe.captureMerge = 1'b1;
            nextState           = ST_MERGE_WR;
          end
        end
      end
      ST_MERGE_WR: begin
        dnValid          = 1'b1;
        dnWrite          = 1'b1;
        reqReady         = 1'b1;
        strobe.useMerged = 1'b1;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/sub_word_datapath.sv
module sub_word_datapath
  import sub_word_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [1:0]        laneSel,
  input  logic [1:0]        sizeCode,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rdWord,
  output logic [DATA_W-1:0] dnData,
  output logic [DATA_W-1:0] rspData
);

  localparam logic [DATA_W-1:0] WINDOW_BASE =
    {{(DATA_W-MERGE_WINDOW_W){1'b0}}, {MERGE_WINDOW_W{1'b1}}};
  localparam logic [DATA_W-1:0] BYTE_KEEP =
    {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

  logic [SHIFT_W-1:0] shiftAmt;
  logic [DATA_W-1:0]  narrowData, laneData, windowMask, mergedWord, mergeReg;

  assign shiftAmt = {laneSel, 3'b000};

  // byte data zero-extended into the 16-bit merge window
  assign narrowData = (sizeCode == SZ_BYTE) ? (wrData & BYTE_KEEP)
                                            : (wrData & WINDOW_BASE);
  assign laneData   = narrowData << shiftAmt;
  assign windowMask = WINDOW_BASE << shiftAmt;
  assign mergedWord = (rdWord & ~windowMask) | laneData;

  always_ff @(posedge clk) begin
    if (!rstN)                    mergeReg <= '0;
    else if (strobe.captureMerge) mergeReg <= mergedWord;
  end

  always_comb begin
    if (strobe.useMerged)          dnData = mergeReg;
    else if (sizeCode == SZ_WORD)  dnData = wrData;
    else                           dnData = laneData;
  end

  assign rspData = (sizeCode == SZ_WORD) ? rdWord : (rdWord >> shiftAmt);

endmodule

// File: rtl/sub_word_adapter.sv
module sub_word_adapter
  import sub_word_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [2**(ADDR_W-2)-1:0] KNOWN_MASK  = 64'h0000_0000_0000_FFFF,
  parameter logic [2**(ADDR_W-2)-1:0] RO_MASK     = 64'h0000_0000_0000_0002,
  parameter logic [2**(ADDR_W-2)-1:0] ACTION_MASK = 64'h0000_0000_0000_0070
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       rspRdata,
  output logic              rspErr,
  output logic              dnValid,
  output logic              dnWrite,
  output logic [ADDR_W-1:0] dnAddr,
  output logic [31:0]       dnWdata,
  input  logic [31:0]       dnRdata
);

  dp_strobe_t strobe;

  assign dnAddr = {reqAddr[ADDR_W-1:2], 2'b00};

  sub_word_ctrl #(
    .ADDR_W     (ADDR_W),
    .KNOWN_MASK (KNOWN_MASK),
    .RO_MASK    (RO_MASK),
    .ACTION_MASK(ACTION_MASK)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .sizeCode(reqSize),
    .wordIdx (reqAddr[ADDR_W-1:2]),
    .reqReady(reqReady),
    .rspErr  (rspErr),
    .dnValid (dnValid),
    .dnWrite (dnWrite),
    .strobe  (strobe)
  );

  sub_word_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .laneSel (reqAddr[1:0]),
    .sizeCode(reqSize),
    .wrData  (reqWdata),
    .rdWord  (dnRdata),
    .dnData  (dnWdata),
    .rspData (rspRdata)
  );

endmodule

// File: rtl/sub_word_adapter_chk.sv
module sub_word_adapter_chk #(
  parameter int ADDR_W = 8,
  parameter logic [2**(ADDR_W-2)-1:0] KNOWN_MASK  = 64'h0000_0000_0000_FFFF,
  parameter logic [2**(ADDR_W-2)-1:0] RO_MASK     = 64'h0000_0000_0000_0002,
  parameter logic [2**(ADDR_W-2)-1:0] ACTION_MASK = 64'h0000_0000_0000_0070
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [1:0]        reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       reqWdata,
  input logic              rspErr,
  input logic              dnValid,
  input logic              dnWrite,
  input logic [ADDR_W-1:0] dnAddr,
  input logic [31:0]       dnWdata
);

  logic [ADDR_W-3:0] idx;
  logic known, narrowWr;
  assign idx      = reqAddr[ADDR_W-1:2];
  assign known    = KNOWN_MASK[idx] && (reqSize != 2'd3);
  assign narrowWr = reqValid && reqWrite && (reqSize < 2'd2) && known;

  p_no_access_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !dnValid && !reqReady);

  p_aligned_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> dnAddr[1:0] == 2'b00 && dnAddr[ADDR_W-1:2] == reqAddr[ADDR_W-1:2]);

  p_word_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqSize == 2'd2 && known)
      |-> dnValid && dnWrite && reqReady && dnWdata == reqWdata);

  p_rmw_second_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && dnValid && !dnWrite)
      |=> dnValid && dnWrite && reqReady && dnAddr == $past(dnAddr));

  p_action_no_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (narrowWr && ACTION_MASK[idx] && !RO_MASK[idx])
      |-> reqReady && dnValid && dnWrite);

  p_ro_dropped_r7: assert property (@(posedge clk) disable iff (!rstN)
    (narrowWr && RO_MASK[idx]) |-> reqReady && !rspErr && !dnValid);

  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !known) |-> reqReady && rspErr && !dnValid);

endmodule

bind sub_word_adapter sub_word_adapter_chk #(
  .ADDR_W     (ADDR_W),
  .KNOWN_MASK (KNOWN_MASK),
  .RO_MASK    (RO_MASK),
  .ACTION_MASK(ACTION_MASK)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqWrite(reqWrite),
  .reqSize (reqSize),
  .reqAddr (reqAddr),
  .reqWdata(reqWdata),
  .rspErr  (rspErr),
  .dnValid (dnValid),
  .dnWrite (dnWrite),
  .dnAddr  (dnAddr),
  .dnWdata (dnWdata)
);

// File: tb/sub_word_adapter_test.sv
module sub_word_adapter_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, reqValid, reqReady, reqWrite, rspErr;
  logic        dnValid, dnWrite;
  logic [1:0]  reqSize;
  logic [7:0]  reqAddr, dnAddr;
  logic [31:0] reqWdata, rspRdata, dnWdata, dnRdata;

  sub_word_adapter #(
    .ADDR_W     (8),
    .KNOWN_MASK (64'h0000_0000_0000_FFFF),
    .RO_MASK    (64'h0000_0000_0000_0002),
    .ACTION_MASK(64'h0000_0000_0000_0070)
  ) uut (.*);

  // downstream register model
  logic [31:0] mem [16];
  assign dnRdata = mem[dnAddr[5:2]];
  always @(posedge clk)
    if (rstN && dnValid && dnWrite) mem[dnAddr[5:2]] <= dnWdata;

  typedef struct { bit isRead; logic [31:0] rdata; bit err; string tag; } rsp_t;
  typedef struct { logic [7:0] addr; logic [31:0] data; string tag; } wr_t;
  rsp_t rspQ[$];
  wr_t  wrQ[$];
  rsp_t r;
  wr_t  w;

  int checks = 0, errors = 0, dnReads = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (dnValid && !dnWrite) dnReads++;
      if (dnValid && dnWrite) begin
        if (wrQ.size() == 0) chk(1'b0, "unexpected downstream write R7", dnWdata, 32'h0);
        else begin
          w = wrQ.pop_front();
          chk(dnAddr == w.addr, {w.tag, " dn addr"}, {24'h0, dnAddr}, {24'h0, w.addr});
          chk(dnWdata == w.data, {w.tag, " dn data"}, dnWdata, w.data);
        end
      end
      if (reqValid && reqReady) begin
        if (rspQ.size() == 0) chk(1'b0, "unexpected response R1", rspRdata, 32'h0);
        else begin
          r = rspQ.pop_front();
          chk(rspErr == r.err, {r.tag, " err"}, {31'h0, rspErr}, {31'h0, r.err});
          if (r.isRead) chk(rspRdata == r.rdata, {r.tag, " rdata"}, rspRdata, r.rdata);
        end
      end
    end
  end

  task automatic expectWrite(input logic [7:0] a, input logic [31:0] d, input string tag);
    wrQ.push_back('{a, d, tag});
  endtask

  task automatic access(input logic [1:0] sz, input bit wr, input logic [7:0] a,
                        input logic [31:0] wd, input logic [31:0] expRd, input bit expErr,
                        input int expLat, input int expReads, input string tag);
    int startReads, lat;
    bit rdy;
    rspQ.push_back('{!wr, expRd, expErr, tag});
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    startReads = dnReads;
    lat = 0;
    do begin
      #2;
      rdy = reqReady;
      lat++;
      @(negedge clk);
    end while (!rdy && lat < 10);
    reqValid = 1'b0;
    chk(lat == expLat, {tag, " latency"}, lat, expLat);
    chk(dnReads - startReads == expReads, {tag, " downstream reads"},
        dnReads - startReads, expReads);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog R1", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqSize = 2'd0;
    reqAddr = 8'h0; reqWdata = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(!dnValid && !reqReady, "R1 idle after reset", {30'h0, dnValid, reqReady}, 32'h0);

    // R3: full-word pass-through
    expectWrite(8'h08, 32'h11223344, "R3 word write");
    access(2'd2, 1, 8'h08, 32'h11223344, 0, 0, 1, 0, "R3 word write");
    access(2'd2, 0, 8'h08, 0, 32'h11223344, 0, 1, 1, "R3 word read");

    // R2: narrow reads, every lane
    access(2'd0, 0, 8'h08, 0, 32'h11223344, 0, 1, 1, "R2 byte lane0");
    access(2'd0, 0, 8'h09, 0, 32'h00112233, 0, 1, 1, "R2 byte lane1");
    access(2'd0, 0, 8'h0A, 0, 32'h00001122, 0, 1, 1, "R2 byte lane2");
    access(2'd0, 0, 8'h0B, 0, 32'h00000011, 0, 1, 1, "R2 byte lane3");
    access(2'd1, 0, 8'h0A, 0, 32'h00001122, 0, 1, 1, "R2 half lane2");

    // R4/R5: byte write at lane 1 wipes lane 2 as well
    expectWrite(8'h08, 32'h1100AB44, "R5 byte merge");
    access(2'd0, 1, 8'h09, 32'hFFFFFFAB, 0, 0, 2, 1, "R5 byte merge");
    access(2'd2, 0, 8'h08, 0, 32'h1100AB44, 0, 1, 1, "R5 readback");

    // R4: half write at lane 2
    expectWrite(8'h0C, 32'hCAFEF00D, "R3 preload");
    access(2'd2, 1, 8'h0C, 32'hCAFEF00D, 0, 0, 1, 0, "R3 preload");
    expectWrite(8'h0C, 32'h1234F00D, "R4 half merge");
    access(2'd1, 1, 8'h0E, 32'hABCD1234, 0, 0, 2, 1, "R4 half merge");
    // R5: lane 3 byte only touches top byte
    expectWrite(8'h0C, 32'h5A34F00D, "R5 lane3 merge");
    access(2'd0, 1, 8'h0F, 32'h0000005A, 0, 0, 2, 1, "R5 lane3 merge");
    access(2'd2, 0, 8'h0C, 0, 32'h5A34F00D, 0, 1, 1, "R4 readback");

    // R6: action registers get zero-padded writes, no read
    expectWrite(8'h10, 32'h00008100, "R6 action byte");
    access(2'd0, 1, 8'h11, 32'hFFFFFF81, 0, 0, 1, 0, "R6 action byte");
    expectWrite(8'h14, 32'hF00F0000, "R6 action half");
    access(2'd1, 1, 8'h16, 32'h5555F00F, 0, 0, 1, 0, "R6 action half");

    // R7: read-only word, full write passes (R3), narrow write dropped
    expectWrite(8'h04, 32'h76543210, "R3 word write to read-only");
    access(2'd2, 1, 8'h04, 32'h76543210, 0, 0, 1, 0, "R3 word write to read-only");
    access(2'd0, 1, 8'h05, 32'h000000FF, 0, 0, 1, 0, "R7 narrow write dropped");
    access(2'd1, 1, 8'h06, 32'h0000BEEF, 0, 0, 1, 0, "R7 half write dropped");
    access(2'd2, 0, 8'h04, 0, 32'h76543210, 0, 1, 1, "R7 word unchanged");

    // R8: refused accesses
    access(2'd2, 0, 8'h80, 0, 0, 1, 1, 0, "R8 unknown read");
    access(2'd0, 1, 8'hC1, 32'h77, 0, 1, 1, 0, "R8 unknown write");
    access(2'd3, 1, 8'h08, 32'hDEADBEEF, 0, 1, 1, 0, "R8 bad size");
    access(2'd2, 0, 8'h08, 0, 32'h1100AB44, 0, 1, 1, "R8 word unchanged");

    repeat (3) @(negedge clk);
    chk(wrQ.size() == 0, "R4 pending downstream writes", wrQ.size(), 0);
    chk(rspQ.size() == 0, "R2 pending responses", rspQ.size(), 0);
    finishRun();
  end

endmodule